// File: doc/BRIEF.md
# Bank Precharge Timing Tracker

This block watches the command stream of a packet-based DRAM channel and keeps, for every bank of every device, a record of when it was last opened and closed. Row commands carry an activate or an explicit precharge. Column commands carry read, write, read-then-close and write-then-close, and a separate extended field may carry a precharge of its own. Every implicit close is turned into an equivalent precharge event at a computed cycle. Closes that follow a write wait for the column packet that retires that write.

From these events the tracker checks three spacings per bank: open to close, close to reopen, and open to open. It raises sticky violation flags that name the offending bank, and it also flags a second scheduled close aimed at a bank whose close is already pending. It never stalls or alters the command stream. A controller or a verification environment uses it to observe legality and bank state.

Top module: `bank_pre_tracker`

## Requirements
- R1: Reset clears all bank state and all flags. A row command with `row_op`=0 (activate) makes `bank_open` of bank index `dev*BANKS_PER_DEV+bank` high from the next cycle on.
- R2: A row command with `row_op`=1 (precharge) to an open bank pulses `pre_evt` of that bank in the same cycle, and the bank reads closed from the next cycle. The same command to a closed bank produces no pulse and no change.
- R3: A column packet with `col_op`=2 (read then close) makes the precharge of its bank take effect exactly OFF_RDA cycles after that packet.
- R4: A precharge in the extended field (`xpre_vld`) takes effect exactly OFF_PRX cycles after its packet.
- R5: Writes (`col_op`=1 plain, `col_op`=3 write then close) are retired by a later column packet. That packet retires the write if it is itself a write. It also retires the write if it arrives at least T_RTR cycles after the write and is not a read (`col_op` 0 or 2) to the write's device. Otherwise retirement is deferred to a later packet.
- R6: For a write-then-close, the precharge takes effect exactly OFF_WRA cycles after the retiring column packet.
- R7: A precharge taking effect fewer than T_RAS cycles after the activate of the same bank sets `ras_err`.
- R8: An activate fewer than T_RP cycles after the last effective precharge of the same bank, or in the same cycle as it, sets `rp_err`.
- R9: An activate fewer than T_RC cycles after the previous activate of the same bank sets `rc_err`.
- R10: A scheduled close requested for a bank that already has one pending sets `cfl_err`, and the new request is dropped. Two requests to one bank in the same cycle also set `cfl_err`. In that case the extended-field precharge wins over read-then-close, which wins over write-then-close.
- R11: Each violation flag stays set until `viol_clr` and keeps the bank index of its first violation. Among banks violating in the same cycle, the lowest index is kept. A violation in the cycle of `viol_clr` sets the flag again with the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_vld | input | 1 | Row command strobe |
| row_op | input | 1 | 0 activate, 1 precharge |
| row_dev | input | DEV_W | Row command device |
| row_bank | input | BANK_W | Row command bank |
| col_vld | input | 1 | Column command strobe |
| col_op | input | 2 | 0 read, 1 write, 2 read then close, 3 write then close |
| col_dev | input | DEV_W | Column command device |
| col_bank | input | BANK_W | Column command bank |
| xpre_vld | input | 1 | Extended-field precharge strobe |
| xpre_dev | input | DEV_W | Extended precharge device |
| xpre_bank | input | BANK_W | Extended precharge bank |
| viol_clr | input | 1 | Clears all violation flags |
| bank_open | output | NB | Open status per bank |
| pre_evt | output | NB | Precharge takes effect this cycle |
| ras_err | output | 1 | Open-to-close spacing violated |
| ras_err_bank | output | IDX_W | Bank of first such violation |
| rp_err | output | 1 | Close-to-open spacing violated |
| rp_err_bank | output | IDX_W | Bank of first such violation |
| rc_err | output | 1 | Open-to-open spacing violated |
| rc_err_bank | output | IDX_W | Bank of first such violation |
| cfl_err | output | 1 | Scheduled-close conflict seen |
| cfl_err_bank | output | IDX_W | Bank of first conflict |

## Verification
`pre_evt` is combinational and is due in the command's own cycle for a row precharge. It is due OFF_RDA or OFF_PRX cycles after a column or extended packet, and OFF_WRA cycles after the retiring packet. `bank_open` and the flags are registered and change one cycle after their cause. The bench keeps a cycle counter and logs, at each falling edge, the cycle in which each bank's pulse was seen. It compares that cycle with the issue cycle plus the offset, and it reads the registered outputs one edge after the cause. Spacing rules are swept gap by gap across their thresholds, and retirement is swept over distance and the kind of follow-up packet.

// File: rtl/bpt_pkg.sv
`timescale 1ns/1ps
package bpt_pkg;

    // row command encoding
    localparam logic ROW_ACT = 1'b0;
    localparam logic ROW_PRE = 1'b1;

    // column command encoding
    typedef enum logic [1:0] {
        COL_RD  = 2'd0,
        COL_WR  = 2'd1,
        COL_RDA = 2'd2,
        COL_WRA = 2'd3
    } col_op_e;

    function automatic logic op_is_write(logic [1:0] op);
        return (op == COL_WR) || (op == COL_WRA);
    endfunction

    function automatic logic op_is_read(logic [1:0] op);
        return (op == COL_RD) || (op == COL_RDA);
    endfunction

endpackage

// File: rtl/bpt_bank.sv
`timescale 1ns/1ps
module bpt_bank #(
    parameter int T_RAS   = 6,
    parameter int T_RP    = 3,
    parameter int T_RC    = 10,
    parameter int OFF_RDA = 2,
    parameter int OFF_PRX = 4,
    parameter int OFF_WRA = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic req_rda_i,
    input  logic req_prx_i,
    input  logic req_wra_i,
    output logic open_o,
    output logic evt_o,
    output logic ras_viol_o,
    output logic rp_viol_o,
    output logic rc_viol_o,
    output logic cfl_o
);
    localparam int AGE_A   = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int AGE_MAX = (AGE_A > T_RC) ? AGE_A : T_RC;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam int OFF_A   = (OFF_RDA > OFF_PRX) ? OFF_RDA : OFF_PRX;
    localparam int OFF_MAX = (OFF_A > OFF_WRA) ? OFF_A : OFF_WRA;
    localparam int OFF_W   = $clog2(OFF_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);

    typedef struct packed {
        logic             open;
        logic             act_seen;
        logic             pre_seen;
        logic [AGE_W-1:0] act_age;
        logic [AGE_W-1:0] pre_age;
        logic             pend_vld;
        logic [OFF_W-1:0] pend_cnt;
    } bank_st_t;

    bank_st_t st_q, st_d;

    logic       expire, evt, eff, busy, cfl;
    logic       ras_v, rp_v, rc_v;
    logic [1:0] nreq;

    function automatic logic [AGE_W-1:0] age_step(logic [AGE_W-1:0] a);
        return (a == AGE_TOP) ? a : a + AGE_W'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        expire = st_q.pend_vld && (st_q.pend_cnt == '0);
        evt    = pre_i || expire;
        eff    = evt && st_q.open;
        busy   = st_q.pend_vld && !expire;
        nreq   = 2'(req_rda_i) + 2'(req_prx_i) + 2'(req_wra_i);
        cfl    = (nreq > 2'd1) || ((nreq != 2'd0) && busy);

        // spacing checks; a close in this cycle is applied before an open
        ras_v = eff && (st_q.act_age < AGE_W'(T_RAS));
        rp_v  = act_i && (eff || (st_q.pre_seen && (st_q.pre_age < AGE_W'(T_RP))));
        rc_v  = act_i && st_q.act_seen && (st_q.act_age < AGE_W'(T_RC));

        // elapsed-time counters
        st_d.act_age = age_step(st_q.act_age);
        st_d.pre_age = age_step(st_q.pre_age);
        if (eff) begin
            st_d.open     = 1'b0;
            st_d.pre_seen = 1'b1;
            st_d.pre_age  = AGE_W'(1);
        end
        if (act_i) begin
            st_d.open     = 1'b1;
            st_d.act_seen = 1'b1;
            st_d.act_age  = AGE_W'(1);
        end

        // scheduled close countdown
        if (expire) begin
            st_d.pend_vld = 1'b0;
        end else if (st_q.pend_vld) begin
            st_d.pend_cnt = st_q.pend_cnt - OFF_W'(1);
        end
        if ((nreq != 2'd0) && !busy) begin
            st_d.pend_vld = 1'b1;
            if (req_prx_i) begin
                st_d.pend_cnt = OFF_W'(OFF_PRX - 1);
            end else if (req_rda_i) begin
                st_d.pend_cnt = OFF_W'(OFF_RDA - 1);
            end else begin
                st_d.pend_cnt = OFF_W'(OFF_WRA - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o     = st_q.open;
    assign evt_o      = eff;
    assign ras_viol_o = ras_v;
    assign rp_viol_o  = rp_v;
    assign rc_viol_o  = rc_v;
    assign cfl_o      = cfl;

endmodule

// File: rtl/bpt_retire.sv
`timescale 1ns/1ps
module bpt_retire
    import bpt_pkg::*;
#(
    parameter int DEV_W = 1,
    parameter int IDX_W = 3,
    parameter int T_RTR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_vld_i,
    input  logic [1:0]       col_op_i,
    input  logic [DEV_W-1:0] col_dev_i,
    input  logic [IDX_W-1:0] col_idx_i,
    output logic             ret_req_o,
    output logic [IDX_W-1:0] ret_idx_o
);
    localparam int AGE_W = $clog2(T_RTR + 1);

    typedef struct packed {
        logic             vld;
        logic             auto_pre;
        logic [DEV_W-1:0] dev;
        logic [IDX_W-1:0] idx;
        logic [AGE_W-1:0] age;
    } wr_slot_t;

    wr_slot_t slot_q, slot_d;
    logic     is_wr, rd_same, aged, retire;

    always_comb begin
        slot_d  = slot_q;
        is_wr   = col_vld_i && op_is_write(col_op_i);
        rd_same = col_vld_i && op_is_read(col_op_i) && (col_dev_i == slot_q.dev);
        aged    = slot_q.age >= AGE_W'(T_RTR);
        retire  = slot_q.vld && col_vld_i && (is_wr || (aged && !rd_same));

        if (slot_q.vld && !aged) begin
            slot_d.age = slot_q.age + AGE_W'(1);
        end
        if (retire) begin
            slot_d.vld = 1'b0;
        end
        if (is_wr) begin
            slot_d.vld      = 1'b1;
            slot_d.auto_pre = (col_op_i == COL_WRA);
            slot_d.dev      = col_dev_i;
            slot_d.idx      = col_idx_i;
            slot_d.age      = AGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ret_req_o = retire && slot_q.auto_pre;
    assign ret_idx_o = slot_q.idx;

endmodule

// File: rtl/bpt_sticky.sv
`timescale 1ns/1ps
module bpt_sticky #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [N-1:0]     hit_i,
    output logic             flag_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic             flag;
        logic [IDX_W-1:0] idx;
    } sticky_t;

    sticky_t st_q, st_d;
    logic [IDX_W-1:0] first;

    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                first = IDX_W'(i);
            end
        end
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end
        if ((|hit_i) && !st_d.flag) begin
            st_d.flag = 1'b1;
            st_d.idx  = first;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign idx_o  = st_q.idx;

endmodule

// File: rtl/bank_pre_tracker.sv
`timescale 1ns/1ps
module bank_pre_tracker
    import bpt_pkg::*;
#(
    parameter int NUM_DEV       = 2,
    parameter int BANKS_PER_DEV = 4,
    parameter int T_RAS         = 6,
    parameter int T_RP          = 3,
    parameter int T_RC          = 10,
    parameter int OFF_RDA       = 2,
    parameter int OFF_PRX       = 4,
    parameter int OFF_WRA       = 3,
    parameter int T_RTR         = 2,
    localparam int NB     = NUM_DEV * BANKS_PER_DEV,
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int BANK_W = (BANKS_PER_DEV > 1) ? $clog2(BANKS_PER_DEV) : 1,
    localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_vld,
    input  logic              row_op,
    input  logic [DEV_W-1:0]  row_dev,
    input  logic [BANK_W-1:0] row_bank,
    input  logic              col_vld,
    input  logic [1:0]        col_op,
    input  logic [DEV_W-1:0]  col_dev,
    input  logic [BANK_W-1:0] col_bank,
    input  logic              xpre_vld,
    input  logic [DEV_W-1:0]  xpre_dev,
    input  logic [BANK_W-1:0] xpre_bank,
    input  logic              viol_clr,
    output logic [NB-1:0]     bank_open,
    output logic [NB-1:0]     pre_evt,
    output logic              ras_err,
    output logic [IDX_W-1:0]  ras_err_bank,
    output logic              rp_err,
    output logic [IDX_W-1:0]  rp_err_bank,
    output logic              rc_err,
    output logic [IDX_W-1:0]  rc_err_bank,
    output logic              cfl_err,
    output logic [IDX_W-1:0]  cfl_err_bank
);
    localparam int N_FLAGS = 4;

    function automatic logic [IDX_W-1:0] flat_idx(logic [DEV_W-1:0] d, logic [BANK_W-1:0] b);
        return IDX_W'(int'(d) * BANKS_PER_DEV + int'(b));
    endfunction

    logic [IDX_W-1:0] row_idx, col_idx, xpre_idx, ret_idx;
    logic             ret_req;
    logic [NB-1:0]    act_v, pre_v, rda_v, prx_v, wra_v;
    logic [NB-1:0]    ras_v, rp_v, rc_v, cfl_v;
    logic [NB-1:0]    hit_arr  [N_FLAGS];
    logic             flag_arr [N_FLAGS];
    logic [IDX_W-1:0] idx_arr  [N_FLAGS];

    // command decode to per-bank strobes
    always_comb begin
        row_idx  = flat_idx(row_dev, row_bank);
        col_idx  = flat_idx(col_dev, col_bank);
        xpre_idx = flat_idx(xpre_dev, xpre_bank);
        for (int i = 0; i < NB; i++) begin
            act_v[i] = row_vld && (row_op == ROW_ACT) && (row_idx == IDX_W'(i));
            pre_v[i] = row_vld && (row_op == ROW_PRE) && (row_idx == IDX_W'(i));
            rda_v[i] = col_vld && (col_op == COL_RDA) && (col_idx == IDX_W'(i));
            prx_v[i] = xpre_vld && (xpre_idx == IDX_W'(i));
            wra_v[i] = ret_req && (ret_idx == IDX_W'(i));
        end
    end

    bpt_retire #(
        .DEV_W (DEV_W),
        .IDX_W (IDX_W),
        .T_RTR (T_RTR)
    ) u_retire (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_vld_i (col_vld),
        .col_op_i  (col_op),
        .col_dev_i (col_dev),
        .col_idx_i (col_idx),
        .ret_req_o (ret_req),
        .ret_idx_o (ret_idx)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bpt_bank #(
            .T_RAS   (T_RAS),
            .T_RP    (T_RP),
            .T_RC    (T_RC),
            .OFF_RDA (OFF_RDA),
            .OFF_PRX (OFF_PRX),
            .OFF_WRA (OFF_WRA)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_v[b]),
            .pre_i      (pre_v[b]),
            .req_rda_i  (rda_v[b]),
            .req_prx_i  (prx_v[b]),
            .req_wra_i  (wra_v[b]),
            .open_o     (bank_open[b]),
            .evt_o      (pre_evt[b]),
            .ras_viol_o (ras_v[b]),
            .rp_viol_o  (rp_v[b]),
            .rc_viol_o  (rc_v[b]),
            .cfl_o      (cfl_v[b])
        );
    end

    assign hit_arr[0] = ras_v;
    assign hit_arr[1] = rp_v;
    assign hit_arr[2] = rc_v;
    assign hit_arr[3] = cfl_v;

    for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
        bpt_sticky #(
            .N     (NB),
            .IDX_W (IDX_W)
        ) u_sticky (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (viol_clr),
            .hit_i  (hit_arr[k]),
            .flag_o (flag_arr[k]),
            .idx_o  (idx_arr[k])
        );
    end

    assign ras_err      = flag_arr[0];
    assign ras_err_bank = idx_arr[0];
    assign rp_err       = flag_arr[1];
    assign rp_err_bank  = idx_arr[1];
    assign rc_err       = flag_arr[2];
    assign rc_err_bank  = idx_arr[2];
    assign cfl_err      = flag_arr[3];
    assign cfl_err_bank = idx_arr[3];

endmodule

// File: rtl/bpt_chk.sv
`timescale 1ns/1ps
module bpt_chk #(
    parameter int BANKS_PER_DEV = 4,
    parameter int NB            = 8,
    parameter int DEV_W         = 1,
    parameter int BANK_W        = 2,
    parameter int IDX_W         = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              row_vld,
    input logic              row_op,
    input logic [DEV_W-1:0]  row_dev,
    input logic [BANK_W-1:0] row_bank,
    input logic              viol_clr,
    input logic [NB-1:0]     bank_open,
    input logic [NB-1:0]     pre_evt,
    input logic              ras_err,
    input logic [IDX_W-1:0]  ras_err_bank,
    input logic              rp_err,
    input logic [IDX_W-1:0]  rp_err_bank,
    input logic              cfl_err,
    input logic [IDX_W-1:0]  cfl_err_bank
);
    logic [IDX_W-1:0] ridx;
    always_comb ridx = IDX_W'(int'(row_dev) * BANKS_PER_DEV + int'(row_bank));

    for (genvar i = 0; i < NB; i++) begin : g_b
        // R1
        open_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (row_vld && !row_op && ridx == IDX_W'(i)) |=> bank_open[i]);
        // R2
        evt_on_row_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (row_vld && row_op && ridx == IDX_W'(i) && bank_open[i]) |-> pre_evt[i]);
        // R2
        evt_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pre_evt[i] |-> bank_open[i]);
        // R2
        closed_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_evt[i] && !(row_vld && !row_op && ridx == IDX_W'(i))) |=> !bank_open[i]);
    end

    // R11
    ras_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_err && !viol_clr) |=> (ras_err && $stable(ras_err_bank)));
    // R11
    rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_err && !viol_clr) |=> (rp_err && $stable(rp_err_bank)));
    // R10
    cfl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfl_err && !viol_clr) |=> (cfl_err && $stable(cfl_err_bank)));

endmodule

bind bank_pre_tracker bpt_chk #(
    .BANKS_PER_DEV (BANKS_PER_DEV),
    .NB            (NB),
    .DEV_W         (DEV_W),
    .BANK_W        (BANK_W),
    .IDX_W         (IDX_W)
) u_bpt_chk (.*);

// File: tb/bank_pre_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_pre_tracker_tb_top;
    localparam int NDEV = 2, BPD = 4, NB = NDEV * BPD;
    localparam int DEV_W = 1, BANK_W = 2, IDX_W = 3;
    localparam int T_RAS = 6, T_RP = 3, T_RC = 10;
    localparam int OFF_RDA = 2, OFF_PRX = 4, OFF_WRA = 3, T_RTR = 2;
    localparam int OP_RD = 0, OP_WR = 1, OP_RDA = 2, OP_WRA = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, row_vld, row_op, col_vld, xpre_vld, viol_clr;
    logic [DEV_W-1:0] row_dev, col_dev, xpre_dev;
    logic [BANK_W-1:0] row_bank, col_bank, xpre_bank;
    logic [1:0] col_op;
    logic [NB-1:0] bank_open, pre_evt;
    logic ras_err, rp_err, rc_err, cfl_err;
    logic [IDX_W-1:0] ras_err_bank, rp_err_bank, rc_err_bank, cfl_err_bank;

    bank_pre_tracker #(
        .NUM_DEV(NDEV), .BANKS_PER_DEV(BPD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
        .OFF_RDA(OFF_RDA), .OFF_PRX(OFF_PRX), .OFF_WRA(OFF_WRA), .T_RTR(T_RTR)
    ) dut_i (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int last_evt [NB];
    int evt_cnt  [NB];
    always @(negedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (pre_evt[i] === 1'b1) begin
                last_evt[i] = cyc;
                evt_cnt[i]  = evt_cnt[i] + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        row_vld = 0; col_vld = 0; xpre_vld = 0; viol_clr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic row(logic op, int idx);
        row_vld = 1; row_op = op;
        row_dev = DEV_W'(idx / BPD); row_bank = BANK_W'(idx % BPD);
    endtask

    task automatic col(int op, int idx);
        col_vld = 1; col_op = 2'(op);
        col_dev = DEV_W'(idx / BPD); col_bank = BANK_W'(idx % BPD);
    endtask

    task automatic xpre(int idx);
        xpre_vld = 1;
        xpre_dev = DEV_W'(idx / BPD); xpre_bank = BANK_W'(idx % BPD);
    endtask

    task automatic clear();
        viol_clr = 1;
        tick();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int e, f, n, fidx, fop;
        bit ret;
        for (int i = 0; i < NB; i++) begin last_evt[i] = -1; evt_cnt[i] = 0; end
        rst_n = 0; row_vld = 0; row_op = 0; col_vld = 0; col_op = 0; xpre_vld = 0; viol_clr = 0;
        row_dev = 0; row_bank = 0; col_dev = 0; col_bank = 0; xpre_dev = 0; xpre_bank = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 / R11 reset state
        chk("R1 reset bank_open", int'(bank_open), 0);
        chk("R11 reset flags", int'({ras_err, rp_err, rc_err, cfl_err}), 0);

        // R1 R2 R7: open-to-close gap sweep on bank 0
        for (int g = 1; g <= 8; g++) begin
            clear();
            row(1'b0, 0); tick();
            chk("R1 open after activate", int'(bank_open[0]), 1);
            repeat (g - 1) tick();
            row(1'b1, 0); e = cyc; tick();
            chk("R2 pulse cycle", last_evt[0], e);
            chk("R2 closed", int'(bank_open[0]), 0);
            chk("R7 ras flag", int'(ras_err), int'(g < T_RAS));
            if (g < T_RAS) chk("R7 ras bank", int'(ras_err_bank), 0);
            idle(12);
        end
        // R2 precharge to a closed bank
        n = evt_cnt[1];
        row(1'b1, 1); tick(); idle(1);
        chk("R2 closed bank no pulse", evt_cnt[1], n);
        chk("R2 closed bank stays closed", int'(bank_open[1]), 0);

        // R8 R9: reopen gap sweep on bank 3
        for (int g = T_RAS + 1; g <= T_RC + 1; g++) begin
            clear();
            row(1'b0, 3); tick();
            repeat (T_RAS - 1) tick();
            row(1'b1, 3); tick();
            repeat (g - T_RAS - 1) tick();
            row(1'b0, 3); tick();
            chk("R8 rp flag", int'(rp_err), int'((g - T_RAS) < T_RP));
            if ((g - T_RAS) < T_RP) chk("R8 rp bank", int'(rp_err_bank), 3);
            chk("R9 rc flag", int'(rc_err), int'(g < T_RC));
            if (g < T_RC) chk("R9 rc bank", int'(rc_err_bank), 3);
            chk("R7 no ras", int'(ras_err), 0);
            idle(T_RAS);
            row(1'b1, 3); tick();
            idle(12);
        end

        // R3 R4: offsets on every bank
        clear();
        for (int i = 0; i < NB; i++) begin
            row(1'b0, i); tick(); idle(T_RAS);
            n = evt_cnt[i];
            col(OP_RDA, i); e = cyc; tick(); idle(6);
            chk("R3 close cycle", last_evt[i], e + OFF_RDA);
            chk("R3 one pulse", evt_cnt[i], n + 1);
            chk("R3 closed", int'(bank_open[i]), 0);
            idle(4);
            row(1'b0, i); tick(); idle(T_RAS);
            xpre(i); col(OP_RD, (i + 1) % NB); e = cyc; tick(); idle(6);
            chk("R4 close cycle", last_evt[i], e + OFF_PRX);
            chk("R4 closed", int'(bank_open[i]), 0);
            idle(4);
        end
        chk("R7 no ras after offsets", int'(ras_err), 0);

        // R5 R6: retirement sweep, write-then-close on bank 2 (device 0)
        for (int d = 1; d <= 4; d++) begin
            for (int k = 0; k < 3; k++) begin
                fop  = (k == 2) ? OP_WR : OP_RD;
                fidx = (k == 1) ? 1 : 5;
                clear();
                row(1'b0, 2); tick(); idle(T_RAS);
                n = evt_cnt[2];
                col(OP_WRA, 2); tick();
                repeat (d - 1) tick();
                col(fop, fidx); f = cyc; tick();
                ret = (k == 2) || (d >= T_RTR && k != 1);
                if (!ret) begin
                    idle(T_RTR + OFF_WRA + 1);
                    chk("R5 retire deferred", evt_cnt[2], n);
                    col(OP_RD, 5); f = cyc; tick();
                end
                idle(6);
                chk("R6 close after retire", last_evt[2], f + OFF_WRA);
                chk("R6 closed", int'(bank_open[2]), 0);
                chk("R7 no ras on retire", int'(ras_err), 0);
                idle(6);
            end
        end

        // R10: conflicts
        clear();
        chk("R10 clear", int'(cfl_err), 0);
        row(1'b0, 5); tick(); idle(T_RAS);
        n = evt_cnt[5];
        col(OP_RDA, 5); e = cyc; tick();
        xpre(5); tick(); idle(8);
        chk("R10 pending conflict", int'(cfl_err), 1);
        chk("R10 pending conflict bank", int'(cfl_err_bank), 5);
        chk("R10 first request kept", last_evt[5], e + OFF_RDA);
        chk("R10 single close", evt_cnt[5], n + 1);
        clear();
        row(1'b0, 6); tick(); idle(T_RAS);
        col(OP_RDA, 6); xpre(6); e = cyc; tick(); idle(8);
        chk("R10 same-cycle conflict", int'(cfl_err), 1);
        chk("R10 same-cycle bank", int'(cfl_err_bank), 6);
        chk("R10 extended field wins", last_evt[6], e + OFF_PRX);

        // R11: lowest index, first kept, clear, set over clear
        idle(12);
        clear();
        row(1'b0, 1); tick();
        row(1'b0, 7); xpre(1); tick();
        tick();
        col(OP_RDA, 7); tick();
        idle(4);
        chk("R11 flag set", int'(ras_err), 1);
        chk("R11 lowest bank", int'(ras_err_bank), 1);
        row(1'b0, 4); tick();
        row(1'b1, 4); tick();
        chk("R11 first bank kept", int'(ras_err_bank), 1);
        viol_clr = 1; tick();
        chk("R11 cleared", int'(ras_err), 0);
        row(1'b0, 0); tick();
        row(1'b1, 0); viol_clr = 1; tick();
        chk("R11 set wins over clear", int'(ras_err), 1);
        chk("R11 new bank", int'(ras_err_bank), 0);

        idle(4);
        finish_run();
    end
endmodule